// File: doc/BRIEF.md
# Dual Microsecond Interval Timer

The block contains two identical interval timers behind one 32-bit word-addressed register bus. A shared prescaler divides the system clock into a one-microsecond tick. Each timer keeps a current count that climbs by one per tick while the timer runs. Software loads the two's complement of the wanted delay, so the count reaches all-ones and wraps after exactly that many microseconds. On the wrap the timer reloads from its next-count register, raises a done flag, and, when enabled, requests an interrupt that carries its own vector.

Software starts a timer by writing the next count, then writing the control word with the run and transfer bits set. Later it reads the current count to see the time left, or it waits for the interrupt. The interrupt is retired either by an acknowledge pulse on the timer's own line or by clearing the done flag. A count of zero at the start gives the full wrap period of 2^CNT_W microseconds.

Top module: `interval_timer_pair`

## Requirements
- R1: After reset, every register of both timers reads zero and neither interrupt request is asserted.
- R2: While RUN (control bit 0) is 1, the current count rises by exactly one per tick, and a tick occurs every DIV clocks. Started from value v, the timer wraps D = 2^CNT_W − v ticks later.
- R3: A starting count of zero gives a delay of 2^CNT_W ticks, not an immediate wrap.
- R4: When RUN is 0, the current count holds its value and does not advance. Clearing RUN freezes the live count.
- R5: Writing the control word with XFER (bit 4) set copies the next count into the current count. Written together with RUN, counting restarts from the copied value. XFER reads back as 0.
- R6: On the wrap from all-ones, DONE (control bit 7) is set, the current count is reloaded from the next count in the same cycle, and counting goes on while RUN stays 1.
- R7: DONE (bit 7) and FAULT (bit 31) are write-one-to-clear. Writing 0 to them leaves them unchanged.
- R8: A wrap that happens while DONE is still set sets FAULT.
- R9: With IE (control bit 6) set, a wrap asserts that timer's interrupt request. The request stays asserted until an acknowledge pulse arrives or DONE is cleared. The vector output shows the vector register.
- R10: The vector register keeps only write-data bits 9:2, and its bits 1:0 always read as zero.
- R11: Word address bit 2 selects the timer, and bits 1:0 select control (0), current count (1), next count (2) or vector (3). Bus writes to the current count are ignored, and one timer's activity never changes the other's registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word address: bit 2 timer, bits 1:0 register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| irq_ack | input | 2 | Per-timer interrupt acknowledge pulse |
| irq_req | output | 2 | Per-timer interrupt request |
| irq_vec0 | output | 10 | Vector of timer 0 |
| irq_vec1 | output | 10 | Vector of timer 1 |

## Verification
The assertions watch, on every cycle, how each timer's count may change from one cycle to the next. The count holds when stopped and holds between ticks. It steps by one on a tick. On a tick at all-ones it reloads the old next count and sets DONE, and a wrap with DONE already set must raise FAULT. An interrupt request without DONE is illegal. The exact wrap delay for a sweep of start values, the full period from zero, the write-one-to-clear behaviour, the vector masking and the retiring of the interrupt by acknowledge or by clearing DONE depend on register sequences, so only the bench scenarios show them.

// File: rtl/itp_pkg.sv
package itp_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CUR  = 2'd1,
    SEL_NEXT = 2'd2,
    SEL_VEC  = 2'd3
  } reg_sel_e;

  localparam int unsigned BIT_RUN   = 0;
  localparam int unsigned BIT_XFER  = 4;
  localparam int unsigned BIT_IE    = 6;
  localparam int unsigned BIT_DONE  = 7;
  localparam int unsigned BIT_FAULT = 31;

  localparam int unsigned VEC_LO = 2;
  localparam int unsigned VEC_HI = 9;
  localparam int unsigned VEC_W  = VEC_HI - VEC_LO + 1;
endpackage

// File: rtl/itp_prescaler.sv
module itp_prescaler #(
  parameter int unsigned DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/itp_channel.sv
module itp_channel
  import itp_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  reg_sel_e         wr_sel,
  input  logic [31:0]      wdata,
  input  logic             ack,
  output logic [31:0]      ctrl_rd,
  output logic [CNT_W-1:0] cur,
  output logic [CNT_W-1:0] nxt,
  output logic [VEC_W-1:0] vec,
  output logic             run,
  output logic             done,
  output logic             fault,
  output logic             irq
);
  logic             run_d, ie_q, ie_d, done_d, fault_d, irq_d;
  logic [CNT_W-1:0] cur_d, nxt_d;
  logic [VEC_W-1:0] vec_d;
  logic             ctrl_wr, count_en, wrap, clr_done, clr_fault;

  always_comb begin
    ctrl_wr   = wr_en && (wr_sel == SEL_CTRL);
    count_en  = run && tick;
    wrap      = count_en && (&cur);
    clr_done  = ctrl_wr && wdata[BIT_DONE];
    clr_fault = ctrl_wr && wdata[BIT_FAULT];

    run_d   = ctrl_wr ? wdata[BIT_RUN] : run;
    ie_d    = ctrl_wr ? wdata[BIT_IE]  : ie_q;
    nxt_d   = (wr_en && wr_sel == SEL_NEXT) ? wdata[CNT_W-1:0] : nxt;
    vec_d   = (wr_en && wr_sel == SEL_VEC) ? wdata[VEC_HI:VEC_LO] : vec;

    if (ctrl_wr && wdata[BIT_XFER]) cur_d = nxt;
    else if (wrap)                  cur_d = nxt;
    else if (count_en)              cur_d = cur + 1'b1;
    else                            cur_d = cur;

    done_d  = (done  && !clr_done)  || wrap;
    fault_d = (fault && !clr_fault) || (wrap && done);

    if (wrap && ie_q)           irq_d = 1'b1;
    else if (ack || clr_done)   irq_d = 1'b0;
    else                        irq_d = irq;

    ctrl_rd            = '0;
    ctrl_rd[BIT_RUN]   = run;
    ctrl_rd[BIT_IE]    = ie_q;
    ctrl_rd[BIT_DONE]  = done;
    ctrl_rd[BIT_FAULT] = fault;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      ie_q  <= 1'b0;
      done  <= 1'b0;
      fault <= 1'b0;
      irq   <= 1'b0;
      cur   <= '0;
      nxt   <= '0;
      vec   <= '0;
    end else begin
      run   <= run_d;
      ie_q  <= ie_d;
      done  <= done_d;
      fault <= fault_d;
      irq   <= irq_d;
      cur   <= cur_d;
      nxt   <= nxt_d;
      vec   <= vec_d;
    end
  end
endmodule

// File: rtl/interval_timer_pair.sv
module interval_timer_pair
  import itp_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned DIV   = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [1:0]  irq_ack,
  output logic [1:0]  irq_req,
  output logic [9:0]  irq_vec0,
  output logic [9:0]  irq_vec1
);
  localparam int unsigned NT = 2;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       us_tick;

  logic [NT-1:0][31:0]      ch_ctrl;
  logic [NT-1:0][CNT_W-1:0] ch_cur;
  logic [NT-1:0][CNT_W-1:0] ch_nxt;
  logic [NT-1:0][VEC_W-1:0] ch_vec;
  logic [NT-1:0]            ch_run, ch_done, ch_fault;

  reg_sel_e sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  itp_prescaler #(.DIV(DIV)) u_presc (
    .clk  (clk),
    .rst_n(rst_int_n),
    .tick (us_tick)
  );

  assign sel = reg_sel_e'(bus_addr[1:0]);

  for (genvar gi = 0; gi < NT; gi++) begin : g_ch
    itp_channel #(.CNT_W(CNT_W)) u_ch (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .tick   (us_tick),
      .wr_en  (bus_wr && (bus_addr[2] == gi[0])),
      .wr_sel (sel),
      .wdata  (bus_wdata),
      .ack    (irq_ack[gi]),
      .ctrl_rd(ch_ctrl[gi]),
      .cur    (ch_cur[gi]),
      .nxt    (ch_nxt[gi]),
      .vec    (ch_vec[gi]),
      .run    (ch_run[gi]),
      .done   (ch_done[gi]),
      .fault  (ch_fault[gi]),
      .irq    (irq_req[gi])
    );
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL: bus_rdata = ch_ctrl[bus_addr[2]];
      SEL_CUR:  bus_rdata = 32'(ch_cur[bus_addr[2]]);
      SEL_NEXT: bus_rdata = 32'(ch_nxt[bus_addr[2]]);
      default:  bus_rdata = {22'd0, ch_vec[bus_addr[2]], 2'b00};
    endcase
  end

  assign irq_vec0 = {ch_vec[0], 2'b00};
  assign irq_vec1 = {ch_vec[1], 2'b00};
endmodule

// File: rtl/interval_timer_pair_chk.sv
module interval_timer_pair_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_wr,
  input logic [2:0]                bus_addr,
  input logic                      tick,
  input logic [1:0]                run,
  input logic [1:0]                done,
  input logic [1:0]                fault,
  input logic [1:0]                irq_req,
  input logic [1:0][CNT_W-1:0]     cur,
  input logic [1:0][CNT_W-1:0]     nxt
);
  for (genvar gi = 0; gi < 2; gi++) begin : g_chk
    logic ctrl_w;
    assign ctrl_w = bus_wr && (bus_addr[2] == gi[0]) && (bus_addr[1:0] == 2'd0);

    AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[gi] && !ctrl_w) |=> $stable(cur[gi])); // R4
    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (run[gi] && !tick && !ctrl_w) |=> $stable(cur[gi])); // R2
    AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (run[gi] && tick && !(&cur[gi]) && !ctrl_w) |=> (cur[gi] == $past(cur[gi]) + 1'b1)); // R2
    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (run[gi] && tick && (&cur[gi]) && !ctrl_w) |=> (cur[gi] == $past(nxt[gi])) && done[gi]); // R6
    AST_FAULT_ON_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (run[gi] && tick && (&cur[gi]) && done[gi]) |=> fault[gi]); // R8
    AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[gi] |-> done[gi]); // R9
  end
endmodule

bind interval_timer_pair interval_timer_pair_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_wr  (bus_wr),
  .bus_addr(bus_addr),
  .tick    (us_tick),
  .run     (ch_run),
  .done    (ch_done),
  .fault   (ch_fault),
  .irq_req (irq_req),
  .cur     (ch_cur),
  .nxt     (ch_nxt)
);

// File: tb/interval_timer_pair_test.sv
module interval_timer_pair_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW  = 8;
  localparam int DV  = 3;
  localparam int FULL = 1 << CW;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [1:0]  irq_ack;
  logic [1:0]  irq_req;
  logic [9:0]  irq_vec0, irq_vec1;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  interval_timer_pair #(.CNT_W(CW), .DIV(DV)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_ack(irq_ack),
    .irq_req(irq_req), .irq_vec0(irq_vec0), .irq_vec1(irq_vec1)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, a, b;
    int n;
    bit seen;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; irq_ack = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int r = 0; r < 8; r++) begin
      rd(3'(r), v);
      check("R1 reset register", v, 32'h0);
    end
    check("R1 reset irq", 32'(irq_req), 32'h0);

    // R10 vector masking
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, v); check("R10 vector mask", v, 32'h3FC);
    wr(3'd3, 32'h0000_01F7);
    rd(3'd3, v); check("R10 vector low bits", v, 32'h1F4);
    check("R10 vector port", 32'(irq_vec0), 32'h1F4);

    // R11 next count readback, current count write ignored
    wr(3'd2, 32'h55);
    rd(3'd2, v); check("R11 next readback", v, 32'h55);
    wr(3'd1, 32'hAB);
    rd(3'd1, v); check("R11 current write ignored", v, 32'h0);

    // R5 transfer without run; R4 no counting while stopped
    wr(3'd0, 32'h10);
    rd(3'd1, v); check("R5 transfer loads current", v, 32'h55);
    rd(3'd0, v); check("R5 transfer reads zero", v, 32'h0);
    repeat (40) @(negedge clk);
    rd(3'd1, v); check("R4 stopped holds", v, 32'h55);

    // R2 R3 R6 sweep of start values
    for (int s = 0; s <= FULL; s += 5) begin
      int sv;
      sv = (s >= FULL) ? FULL - 1 : s;
      wr(3'd0, 32'h8000_0080);
      wr(3'd2, 32'(sv));
      wr(3'd0, 32'h11);
      n = 0;
      rd(3'd0, v);
      while (v[7] == 1'b0 && n < 2000) begin
        @(negedge clk); n++;
        rd(3'd0, v);
      end
      begin
        int d;
        d = FULL - sv;
        checks++;
        if (n < (d-1)*DV + 1 || n > d*DV) begin
          fails++;
          $display("FAIL %s start=%0d actual=%0d expected=%0d..%0d",
                   (sv == 0) ? "R3 full period" : "R2 wrap delay", sv, n, (d-1)*DV+1, d*DV);
        end
      end
      rd(3'd1, a);
      check("R6 reload at wrap", a, 32'(sv));
    end

    // R7 writing zero leaves DONE; writing one clears
    wr(3'd0, 32'h1);
    rd(3'd0, v); check("R7 done kept by zero write", 32'(v[7]), 32'h1);
    wr(3'd0, 32'h80);
    rd(3'd0, v); check("R7 done cleared", 32'(v[7]), 32'h0);

    // R4 freeze on run clear
    wr(3'd2, 32'h10);
    wr(3'd0, 32'h11);
    repeat (30) @(negedge clk);
    wr(3'd0, 32'h0);
    rd(3'd1, a);
    repeat (40) @(negedge clk);
    rd(3'd1, b);
    check("R4 frozen value", b, a);
    check("R4 advanced before stop", 32'(a > 32'h10 && a < 32'h20), 32'h1);

    // R8 second wrap sets FAULT; R7 FAULT w1c
    wr(3'd2, 32'hFE);
    wr(3'd0, 32'h11);
    repeat (25) @(negedge clk);
    wr(3'd0, 32'h0);
    rd(3'd0, v);
    check("R8 done set", 32'(v[7]), 32'h1);
    check("R8 fault set", 32'(v[31]), 32'h1);
    wr(3'd0, 32'h8000_0000);
    rd(3'd0, v);
    check("R7 fault cleared", 32'(v[31]), 32'h0);
    check("R7 done untouched", 32'(v[7]), 32'h1);
    wr(3'd0, 32'h80);

    // R9 interrupt with acknowledge
    wr(3'd0, 32'h51);
    seen = 0;
    for (int k = 0; k < 60 && !seen; k++) begin
      @(negedge clk);
      if (irq_req[0]) seen = 1;
    end
    wr(3'd0, 32'h40);
    check("R9 irq raised", 32'(seen), 32'h1);
    check("R9 irq vector", 32'(irq_vec0), 32'h1F4);
    check("R11 other irq quiet", 32'(irq_req[1]), 32'h0);
    @(negedge clk); irq_ack = 2'b01;
    @(negedge clk); irq_ack = 2'b00;
    check("R9 irq retired by ack", 32'(irq_req[0]), 32'h0);
    rd(3'd0, v); check("R9 done after ack", 32'(v[7]), 32'h1);

    // R9 interrupt retired by clearing DONE
    wr(3'd0, 32'hC0);
    wr(3'd0, 32'h51);
    seen = 0;
    for (int k = 0; k < 60 && !seen; k++) begin
      @(negedge clk);
      if (irq_req[0]) seen = 1;
    end
    wr(3'd0, 32'h40);
    check("R9 irq raised again", 32'(seen), 32'h1);
    wr(3'd0, 32'hC0);
    check("R9 irq retired by done clear", 32'(irq_req[0]), 32'h0);

    // R11 timer independence
    rd(3'd1, a);
    wr(3'd6, 32'h24);
    wr(3'd7, 32'h7C);
    wr(3'd4, 32'h11);
    repeat (30) @(negedge clk);
    rd(3'd1, b);
    check("R11 timer0 untouched", b, a);
    rd(3'd5, b);
    check("R11 timer1 counting", 32'(b > 32'h24), 32'h1);
    rd(3'd2, b); check("R11 timer0 next untouched", b, 32'hFE);
    check("R11 timer1 vector", 32'(irq_vec1), 32'h7C);
    wr(3'd4, 32'h0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule